// File: doc/BRIEF.md
# Staggered Half-Word Adder Pipeline

This block is a 32-bit integer adder for a fast execution loop. It spreads one addition over three consecutive ticks of a single fast clock, and each tick stands for one phase. In the first tick it forms the lower 16 bits and their carry. In the second tick it forms the upper 16 bits from that registered carry. In the third tick it derives the condition flags. A new add may be issued on every tick.

Each half of a result goes back to the operand inputs as soon as it exists. A consumer issued on the very next tick takes the producer's lower half during its own low phase. It takes the producer's upper half during its own high phase, one tick later. Chains of dependent adds therefore run at one per tick with no stall. The lower half leaves the block early on its own port, so logic downstream can start on it, for example to use it as a cache index, before the upper half is known.

Top module: `stag_add_pipe`

## Requirements
- R1: An add issued with `in_valid` high in cycle t drives `lo_valid` high in cycle t+1, and `res_lo` then holds bits 15..0 of its sum.
- R2: That add drives `hi_valid` high in cycle t+2, and `res_hi` then holds bits 31..16 of its sum, including the carry out of bit 15.
- R3: That add drives `done_valid` high in cycle t+3, with the full 32-bit sum on `done_sum`. Adds may be issued in consecutive cycles, and results come out once each, in issue order.
- R4: `flag_z` is high in the final phase exactly when all 32 bits of the sum are zero.
- R5: `flag_c` is the unsigned carry out of bit 31 of the add.
- R6: `flag_n` equals bit 31 of the sum. `flag_v` is high when both operands have the same bit 31 and the sum's bit 31 differs from it (signed overflow).
- R7: When `byp_a` (or `byp_b`) is high, operand A (or B) is replaced by the full 32-bit result of the add issued in the previous cycle, and the value on `opa` (or `opb`) is ignored. Its low half is taken in the consumer's low phase and its high half in the consumer's high phase. If both selects are high, the result is added to itself.
- R8: A cycle with `in_valid` low issues nothing. The operands and selects seen in that cycle cause no `lo_valid`, `hi_valid` or `done_valid` pulse later.
- R9: Reset is synchronous and active high. It clears all three valid outputs and discards any add still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one rising edge per phase |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an add this cycle |
| byp_a | input | 1 | Take operand A from the previous add's result |
| byp_b | input | 1 | Take operand B from the previous add's result |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| lo_valid | output | 1 | Lower result half valid |
| res_lo | output | 16 | Lower result half |
| hi_valid | output | 1 | Upper result half valid |
| res_hi | output | 16 | Upper result half |
| done_valid | output | 1 | Full result and flags valid |
| done_sum | output | 32 | Full 32-bit sum |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Sign flag |
| flag_c | output | 1 | Carry-out flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
On every cycle, the assertions check the valid relay from issue to the low, high and final phases. They also check that the lower half and the upper half reach the final output unchanged from the ports where they first appeared. Only the bench's scenarios can show arithmetic correctness. That covers the carry crossing the half boundary, the flag values, and the correct operand choice for a bypassed consumer whose producer's upper half is still being computed. The bench checks these against its own reference sum over dependent chains issued every cycle, idle gaps and a reset during flight.

// File: rtl/stag_add_pkg.sv
package stag_add_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;

    // State after the low phase
    typedef struct packed {
        logic  vld;
        half_t sum_lo;
        logic  cy;
        half_t a_hi;
        half_t b_hi;
        logic  byp_a;
        logic  byp_b;
    } lo_stage_t;

    // State after the high phase
    typedef struct packed {
        logic  vld;
        half_t sum_lo;
        half_t sum_hi;
        logic  cy;
        logic  ovf;
        logic  lo_zero;
    } hi_stage_t;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    // Half-width add with carry in; MSB of result is carry out
    function automatic logic [HALF_W:0] half_add(input half_t a, input half_t b, input logic cin);
        return {1'b0, a} + {1'b0, b} + {{HALF_W{1'b0}}, cin};
    endfunction

endpackage

// File: rtl/stag_lo_phase.sv
module stag_lo_phase
    import stag_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              byp_a,
    input  logic              byp_b,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output lo_stage_t         lo_q
);

    half_t           a_lo;
    half_t           b_lo;
    logic [HALF_W:0] s_lo;
    lo_stage_t       lo_d;

    // Low-half forward: previous issue's low sum sits in lo_q this cycle
    always_comb begin
        a_lo         = byp_a ? lo_q.sum_lo : opa[HALF_W-1:0];
        b_lo         = byp_b ? lo_q.sum_lo : opb[HALF_W-1:0];
        s_lo         = half_add(a_lo, b_lo, 1'b0);
        lo_d.vld     = in_valid;
        lo_d.sum_lo  = s_lo[HALF_W-1:0];
        lo_d.cy      = s_lo[HALF_W];
        lo_d.a_hi    = opa[WORD_W-1:HALF_W];
        lo_d.b_hi    = opb[WORD_W-1:HALF_W];
        lo_d.byp_a   = byp_a;
        lo_d.byp_b   = byp_b;
    end

    always_ff @(posedge clk) begin
        if (rst) lo_q <= '0;
        else     lo_q <= lo_d;
    end

    // R1: an issued add reaches the low-phase output on the next cycle
    assert_lo_follows_issue_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> lo_q.vld);

    // R8: an idle cycle produces no low-phase result
    assert_idle_no_lo_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !lo_q.vld);

endmodule

// File: rtl/stag_hi_phase.sv
module stag_hi_phase
    import stag_add_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lo_stage_t lo_q,
    output hi_stage_t hi_q
);

    half_t           a_hi;
    half_t           b_hi;
    logic [HALF_W:0] s_hi;
    hi_stage_t       hi_d;

    // High-half forward: producer's high sum sits in hi_q this cycle
    always_comb begin
        a_hi         = lo_q.byp_a ? hi_q.sum_hi : lo_q.a_hi;
        b_hi         = lo_q.byp_b ? hi_q.sum_hi : lo_q.b_hi;
        s_hi         = half_add(a_hi, b_hi, lo_q.cy);
        hi_d.vld     = lo_q.vld;
        hi_d.sum_lo  = lo_q.sum_lo;
        hi_d.sum_hi  = s_hi[HALF_W-1:0];
        hi_d.cy      = s_hi[HALF_W];
        hi_d.ovf     = (a_hi[HALF_W-1] == b_hi[HALF_W-1]) &&
                       (s_hi[HALF_W-1] != a_hi[HALF_W-1]);
        hi_d.lo_zero = (lo_q.sum_lo == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) hi_q <= '0;
        else     hi_q <= hi_d;
    end

    // R2: the high phase follows the low phase by one cycle
    assert_hi_follows_lo_R2: assert property (@(posedge clk) disable iff (rst)
        lo_q.vld |=> hi_q.vld);

    // R1: the low half is carried through the high phase unchanged
    assert_lo_carried_R1: assert property (@(posedge clk) disable iff (rst)
        lo_q.vld |=> (hi_q.sum_lo == $past(lo_q.sum_lo)));

endmodule

// File: rtl/stag_flag_phase.sv
module stag_flag_phase
    import stag_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hi_stage_t         hi_q,
    output logic              done_vld,
    output logic [WORD_W-1:0] done_sum,
    output flags_t            done_flags
);

    flags_t fl_d;

    always_comb begin
        fl_d.z = hi_q.lo_zero && (hi_q.sum_hi == '0);
        fl_d.n = hi_q.sum_hi[HALF_W-1];
        fl_d.c = hi_q.cy;
        fl_d.v = hi_q.ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_vld   <= 1'b0;
            done_sum   <= '0;
            done_flags <= '0;
        end else begin
            done_vld   <= hi_q.vld;
            done_sum   <= {hi_q.sum_hi, hi_q.sum_lo};
            done_flags <= fl_d;
        end
    end

    // R3: the flag phase follows the high phase by one cycle
    assert_done_follows_hi_R3: assert property (@(posedge clk) disable iff (rst)
        hi_q.vld |=> done_vld);

    // R2: the high half reaches the final output unchanged
    assert_hi_carried_R2: assert property (@(posedge clk) disable iff (rst)
        hi_q.vld |=> (done_sum[WORD_W-1:HALF_W] == $past(hi_q.sum_hi)));

endmodule

// File: rtl/stag_add_pipe.sv
module stag_add_pipe
    import stag_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              byp_a,
    input  logic              byp_b,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              lo_valid,
    output logic [HALF_W-1:0] res_lo,
    output logic              hi_valid,
    output logic [HALF_W-1:0] res_hi,
    output logic              done_valid,
    output logic [WORD_W-1:0] done_sum,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v
);

    lo_stage_t lo_q;
    hi_stage_t hi_q;
    flags_t    fl_q;

    stag_lo_phase u_lo (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .byp_a    (byp_a),
        .byp_b    (byp_b),
        .opa      (opa),
        .opb      (opb),
        .lo_q     (lo_q)
    );

    stag_hi_phase u_hi (
        .clk  (clk),
        .rst  (rst),
        .lo_q (lo_q),
        .hi_q (hi_q)
    );

    stag_flag_phase u_fl (
        .clk        (clk),
        .rst        (rst),
        .hi_q       (hi_q),
        .done_vld   (done_valid),
        .done_sum   (done_sum),
        .done_flags (fl_q)
    );

    assign lo_valid = lo_q.vld;
    assign res_lo   = lo_q.sum_lo;
    assign hi_valid = hi_q.vld;
    assign res_hi   = hi_q.sum_hi;
    assign flag_z   = fl_q.z;
    assign flag_n   = fl_q.n;
    assign flag_c   = fl_q.c;
    assign flag_v   = fl_q.v;

    // R1: the early low half seen at the port matches the final low half
    assert_lo_port_final_R1: assert property (@(posedge clk) disable iff (rst)
        lo_valid |=> ##1 (done_valid && (done_sum[HALF_W-1:0] == $past(res_lo, 2))));

    // R3: at most one phase output per op; the valid relay never gaps mid-flight
    assert_relay_R3: assert property (@(posedge clk) disable iff (rst)
        hi_valid |-> $past(lo_valid));

endmodule

// File: tb/stag_add_pipe_tb.sv
`timescale 1ns/1ps
module stag_add_pipe_tb;
    import stag_add_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              byp_a;
    logic              byp_b;
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic              lo_valid;
    logic [HALF_W-1:0] res_lo;
    logic              hi_valid;
    logic [HALF_W-1:0] res_hi;
    logic              done_valid;
    logic [WORD_W-1:0] done_sum;
    logic              flag_z;
    logic              flag_n;
    logic              flag_c;
    logic              flag_v;

    int tests  = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    stag_add_pipe u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .byp_a(byp_a), .byp_b(byp_b),
        .opa(opa), .opb(opb), .lo_valid(lo_valid), .res_lo(res_lo),
        .hi_valid(hi_valid), .res_hi(res_hi), .done_valid(done_valid),
        .done_sum(done_sum), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    // {valid, byp_a, byp_b, opa, opb}
    localparam int NV = 18;
    localparam logic [66:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0002},
        {1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001},  // carry across halves
        {1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0000_FFFF},  // dependent on prior
        {1'b1, 1'b1, 1'b0, 32'h1234_5678, 32'h0001_0001},
        {1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000},  // doubled
        {1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001},  // signed overflow
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001},  // zero with carry
        {1'b0, 1'b1, 1'b1, 32'hAAAA_AAAA, 32'h5555_5555},  // idle: ignored
        {1'b0, 1'b0, 1'b0, 32'h1111_1111, 32'h2222_2222},
        {1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000},  // neg overflow, zero
        {1'b1, 1'b0, 1'b1, 32'h0001_8000, 32'h0000_0000},
        {1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0000},  // carry via bypass
        {1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFD_0000},
        {1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_FFFF},
        {1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001},
        {1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 1'b0, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF},  // negative, no carry
        {1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000}
    };

    logic [WORD_W-1:0] exp_sum [64];
    logic [3:0]        exp_fl  [64];   // {z,n,c,v}
    int                n_iss, n_lo, n_hi, n_done;
    logic [2:0]        ev;             // expected valids {done,hi,lo}
    logic [WORD_W-1:0] prev;

    task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic monitor();
        check(lo_valid == ev[0], "R1/R8 lo_valid", {31'b0, lo_valid}, {31'b0, ev[0]});
        check(hi_valid == ev[1], "R2/R8 hi_valid", {31'b0, hi_valid}, {31'b0, ev[1]});
        check(done_valid == ev[2], "R3/R8 done_valid", {31'b0, done_valid}, {31'b0, ev[2]});
        if (lo_valid && ev[0]) begin
            check(res_lo == exp_sum[n_lo][15:0], "R1 res_lo", {16'b0, res_lo},
                  {16'b0, exp_sum[n_lo][15:0]});
            n_lo++;
        end
        if (hi_valid && ev[1]) begin
            check(res_hi == exp_sum[n_hi][31:16], "R2 res_hi", {16'b0, res_hi},
                  {16'b0, exp_sum[n_hi][31:16]});
            n_hi++;
        end
        if (done_valid && ev[2]) begin
            check(done_sum == exp_sum[n_done], "R3/R7 done_sum", done_sum, exp_sum[n_done]);
            check(flag_z == exp_fl[n_done][3], "R4 flag_z", {31'b0, flag_z}, {31'b0, exp_fl[n_done][3]});
            check(flag_c == exp_fl[n_done][1], "R5 flag_c", {31'b0, flag_c}, {31'b0, exp_fl[n_done][1]});
            check({flag_n, flag_v} == {exp_fl[n_done][2], exp_fl[n_done][0]}, "R6 flag_n/flag_v",
                  {30'b0, flag_n, flag_v}, {30'b0, exp_fl[n_done][2], exp_fl[n_done][0]});
            n_done++;
        end
    endtask

    // Drive one cycle; input applied now is sampled at the next rising edge
    task automatic step(input logic v, input logic ba, input logic bb,
                        input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
        logic [WORD_W-1:0] ea, eb;
        logic [WORD_W:0]   s;
        in_valid = v; byp_a = ba; byp_b = bb; opa = a; opb = b;
        if (v) begin
            ea = ba ? prev : a;
            eb = bb ? prev : b;
            s  = {1'b0, ea} + {1'b0, eb};
            exp_sum[n_iss] = s[WORD_W-1:0];
            exp_fl[n_iss]  = {s[WORD_W-1:0] == '0, s[WORD_W-1], s[WORD_W],
                              (ea[WORD_W-1] == eb[WORD_W-1]) && (s[WORD_W-1] != ea[WORD_W-1])};
            prev = s[WORD_W-1:0];
            n_iss++;
        end
        @(posedge clk);
        ev = rst ? 3'b000 : {ev[1:0], v};
        @(negedge clk);
        monitor();
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; byp_a = 0; byp_b = 0; opa = '0; opb = '0;
        n_iss = 0; n_lo = 0; n_hi = 0; n_done = 0; ev = '0; prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check({lo_valid, hi_valid, done_valid} == 3'b000, "R9 reset valids",
              {29'b0, lo_valid, hi_valid, done_valid}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, '0);
        check(n_done == n_iss, "R3 result count", n_done, n_iss);

        // R9: reset while two adds are in flight discards them
        step(1'b1, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0006);
        step(1'b1, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0008);
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0, '0);
        rst = 1'b0;
        check({lo_valid, hi_valid, done_valid} == 3'b000, "R9 flush",
              {29'b0, lo_valid, hi_valid, done_valid}, '0);
        n_lo = n_iss; n_hi = n_iss; n_done = n_iss;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, '0);
        check(n_done == n_iss, "R9 no stale result", n_done, n_iss);

        // Back-to-back after reset
        step(1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
        step(1'b1, 1'b1, 1'b1, '0, '0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, '0);
        check(n_done == n_iss, "R7 chain after reset count", n_done, n_iss);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule